// File: doc/BRIEF.md
# At-Speed Strobe Sweep Sequencer

This block runs in the rated clock domain. It sequences a delay test in which the flip-flops of the circuit under test keep receiving the full rated clock, while stimulus is applied and responses are sampled at a slower test rate. A programmable speed-reduction factor N sets the length of each test cycle to N rated periods. An apply pulse marks the first rated cycle of every test cycle. The block drives the vector index that the stimulus source uses. A single sample strobe falls k rated cycles into the test cycle, counting the apply cycle as position 1.

The whole vector set is replayed N times. The strobe offset k is 1 on the first pass and grows by one rated period on each later pass, until the last pass samples at offset N. On every strobe, a capture register takes the circuit outputs and compares them with the expected word supplied for the current vector. A sticky fail flag is kept, together with the pass number and vector index of the first mismatch, so the slowest path that fails can be located.

Top module: `strobe_sweep_seq`

## Requirements
- R1: After synchronous reset, busy, done, applyPulse, strobe and failSticky are 0, and passNum, vecIndex, failPass, failVec and captured are 0.
- R2: A start pulse while idle is accepted at that clock edge. It latches speedFactor as N (0 is taken as 1) and vecCount as V (0 is taken as 1). From the next cycle busy is 1, with passNum = 1 and vecIndex = 0.
- R3: Each test cycle lasts exactly N rated cycles. applyPulse is high only in the first of them. vecIndex holds for the whole test cycle and steps 0, 1, ..., V-1 across a pass.
- R4: Exactly one strobe pulse, one rated cycle wide, occurs in each test cycle. It falls at position passNum, where the apply cycle is position 1, so for k = 1 it coincides with applyPulse.
- R5: passNum starts at 1 and increments by one after the test cycle of vector V-1 ends. The run contains passes 1 through N.
- R6: When the test cycle of vector V-1 in pass N ends, busy falls and done rises in the same cycle. A run therefore lasts N*N*V busy cycles. done stays high until the next accepted start.
- R7: captured loads cutOut at the clock edge that ends a strobe cycle and holds its value at every other edge.
- R8: On a strobe cycle where cutOut differs from expData, failSticky sets at that edge. failPass and failVec record the passNum and vecIndex of the first such mismatch, and later mismatches leave them unchanged. A difference on a non-strobe cycle has no effect.
- R9: A start pulse while busy is ignored. The sequence, N and V carry on unchanged.
- R10: An accepted start clears done, failSticky, failPass and failVec.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rated clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (honoured only while idle) |
| speedFactor | input | FACTOR_W | Speed-reduction factor N, 0 taken as 1 |
| vecCount | input | VEC_W | Number of vectors per pass, 0 taken as 1 |
| cutOut | input | DATA_W | Outputs of the circuit under test |
| expData | input | DATA_W | Expected word for the current vector |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last pass finished |
| applyPulse | output | 1 | First rated cycle of a test cycle |
| strobe | output | 1 | Output sample strobe |
| vecIndex | output | VEC_W | Current vector index |
| passNum | output | FACTOR_W | Current strobe offset k |
| captured | output | DATA_W | Last sampled output word |
| failSticky | output | 1 | Some strobed sample mismatched |
| failPass | output | FACTOR_W | Pass of the first mismatch |
| failVec | output | VEC_W | Vector of the first mismatch |

## Verification
The bench sweeps N over the edges 0, 1 and 15 as well as random values, with vector counts of 0, 1 and several. A design that mishandles N = 1 or k = N would drop the strobe, put it on the wrong cycle, or put it outside the test cycle, and the per-cycle position checks report that. Non-strobe cycles carry deliberately wrong data, so a design that compares or captures off the strobe shows a false failure or a wrong captured word. A second injected mismatch, plus a start pulse issued in the middle of a run, expose a record of the first failure that gets overwritten and a start that is not ignored.

// File: rtl/strobe_sweep_pkg.sv
package strobe_sweep_pkg;
  // Strobes passed from the sequencing control to the capture datapath
  typedef struct packed {
    logic applyPulse;
    logic strobe;
    logic clearStatus;
  } seq_ctl_t;
endpackage

// File: rtl/strobe_sweep_ctrl.sv
module strobe_sweep_ctrl
  import strobe_sweep_pkg::*;
#(
  parameter int FACTOR_W = 4,
  parameter int VEC_W    = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [FACTOR_W-1:0] speedFactor,
  input  logic [VEC_W-1:0]    vecCount,
  output seq_ctl_t            ctl,
  output logic                busy,
  output logic                done,
  output logic [VEC_W-1:0]    vecIndex,
  output logic [FACTOR_W-1:0] passNum
);
  localparam logic [FACTOR_W-1:0] ONE_F = FACTOR_W'(1);
  localparam logic [VEC_W-1:0]    ONE_V = VEC_W'(1);

  logic [FACTOR_W-1:0] phase;
  logic [FACTOR_W-1:0] nLat;
  logic [VEC_W-1:0]    vLast;
  logic                accept;
  logic                cycleEnd;
  logic                passEnd;

  assign accept   = start && !busy;
  assign cycleEnd = busy && (phase == nLat);
  assign passEnd  = cycleEnd && (vecIndex == vLast);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      done     <= 1'b0;
      phase    <= '0;
      passNum  <= '0;
      vecIndex <= '0;
      nLat     <= ONE_F;
      vLast    <= '0;
    end else if (accept) begin
      busy     <= 1'b1;
      done     <= 1'b0;
      phase    <= ONE_F;
      passNum  <= ONE_F;
      vecIndex <= '0;
      nLat     <= (speedFactor == '0) ? ONE_F : speedFactor;
      vLast    <= (vecCount == '0) ? '0 : VEC_W'(vecCount - ONE_V);
    end else if (busy) begin
      if (cycleEnd) begin
        phase <= ONE_F;
        if (passEnd) begin
          vecIndex <= '0;
          if (passNum == nLat) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            passNum <= passNum + ONE_F;
          end
        end else begin
          vecIndex <= vecIndex + ONE_V;
        end
      end else begin
        phase <= phase + ONE_F;
      end
    end
  end

  always_comb begin
    ctl.applyPulse  = busy && (phase == ONE_F);
    ctl.strobe      = busy && (phase == passNum);
    ctl.clearStatus = accept;
  end

  // Checker state: has a strobe already occurred in this test cycle
  logic seenStrobe;
  always_ff @(posedge clk) begin
    if (rst) seenStrobe <= 1'b0;
    else if (ctl.applyPulse) seenStrobe <= ctl.strobe;
    else if (ctl.strobe) seenStrobe <= 1'b1;
  end

  // R4
  single_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl.strobe && !ctl.applyPulse) |-> !seenStrobe);

  // R4
  strobe_before_end_chk: assert property (@(posedge clk) disable iff (rst)
    cycleEnd |-> (seenStrobe || ctl.strobe));

  // R3
  vec_moves_at_apply_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && vecIndex != $past(vecIndex)) |-> ctl.applyPulse);

  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> ($stable(nLat) && $stable(vLast)));

  // R5
  pass_in_range_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> (passNum >= ONE_F && passNum <= nLat));
endmodule

// File: rtl/strobe_sweep_dp.sv
module strobe_sweep_dp
  import strobe_sweep_pkg::*;
#(
  parameter int FACTOR_W = 4,
  parameter int VEC_W    = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  seq_ctl_t            ctl,
  input  logic [FACTOR_W-1:0] passNum,
  input  logic [VEC_W-1:0]    vecIndex,
  input  logic [DATA_W-1:0]   cutOut,
  input  logic [DATA_W-1:0]   expData,
  output logic [DATA_W-1:0]   captured,
  output logic                failSticky,
  output logic [FACTOR_W-1:0] failPass,
  output logic [VEC_W-1:0]    failVec
);
  logic mismatch;
  assign mismatch = ctl.strobe && (cutOut != expData);

  always_ff @(posedge clk) begin
    if (rst) captured <= '0;
    else if (ctl.strobe) captured <= cutOut;
  end

  always_ff @(posedge clk) begin
    if (rst || ctl.clearStatus) begin
      failSticky <= 1'b0;
      failPass   <= '0;
      failVec    <= '0;
    end else if (mismatch && !failSticky) begin
      failSticky <= 1'b1;
      failPass   <= passNum;
      failVec    <= vecIndex;
    end
  end

  // R7
  capture_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl.strobe |=> $stable(captured));

  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (failSticky && !ctl.clearStatus) |=> (failSticky && $stable(failPass) && $stable(failVec)));

  // R10
  clear_status_chk: assert property (@(posedge clk) disable iff (rst)
    ctl.clearStatus |=> !failSticky);
endmodule

// File: rtl/strobe_sweep_seq.sv
module strobe_sweep_seq
  import strobe_sweep_pkg::*;
#(
  parameter int FACTOR_W = 4,
  parameter int VEC_W    = 4,
  parameter int DATA_W   = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [FACTOR_W-1:0] speedFactor,
  input  logic [VEC_W-1:0]    vecCount,
  input  logic [DATA_W-1:0]   cutOut,
  input  logic [DATA_W-1:0]   expData,
  output logic                busy,
  output logic                done,
  output logic                applyPulse,
  output logic                strobe,
  output logic [VEC_W-1:0]    vecIndex,
  output logic [FACTOR_W-1:0] passNum,
  output logic [DATA_W-1:0]   captured,
  output logic                failSticky,
  output logic [FACTOR_W-1:0] failPass,
  output logic [VEC_W-1:0]    failVec
);
  seq_ctl_t ctl;

  strobe_sweep_ctrl #(.FACTOR_W(FACTOR_W), .VEC_W(VEC_W)) ctrl_i (
    .clk(clk), .rst(rst), .start(start), .speedFactor(speedFactor),
    .vecCount(vecCount), .ctl(ctl), .busy(busy), .done(done),
    .vecIndex(vecIndex), .passNum(passNum)
  );

  strobe_sweep_dp #(.FACTOR_W(FACTOR_W), .VEC_W(VEC_W), .DATA_W(DATA_W)) dp_i (
    .clk(clk), .rst(rst), .ctl(ctl), .passNum(passNum), .vecIndex(vecIndex),
    .cutOut(cutOut), .expData(expData), .captured(captured),
    .failSticky(failSticky), .failPass(failPass), .failVec(failVec)
  );

  assign applyPulse = ctl.applyPulse;
  assign strobe     = ctl.strobe;
endmodule

// File: tb/strobe_sweep_seq_tb.sv
module strobe_sweep_seq_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic [3:0] speedFactor = '0;
  logic [3:0] vecCount = '0;
  logic [7:0] cutOut = '0;
  logic [7:0] expData = '0;
  logic       busy, done, applyPulse, strobe, failSticky;
  logic [3:0] vecIndex, passNum, failPass, failVec;
  logic [7:0] captured;

  int checks = 0;
  int fails = 0;
  int cycles = 0;
  int expCap = 0;

  always #5 clk = ~clk;

  strobe_sweep_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .speedFactor(speedFactor),
    .vecCount(vecCount), .cutOut(cutOut), .expData(expData), .busy(busy),
    .done(done), .applyPulse(applyPulse), .strobe(strobe), .vecIndex(vecIndex),
    .passNum(passNum), .captured(captured), .failSticky(failSticky),
    .failPass(failPass), .failVec(failVec)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int effOf(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  // one run: factor n, vector count v, first injected mismatch (injP,injV; injP=0 none),
  // second mismatch at the last strobe when inj2, stray start at cycle midT (-1 none)
  task automatic runTest(input int n, input int v, input int injP, input int injV,
                         input bit inj2, input int midT);
    int ne = effOf(n);
    int ve = effOf(v);
    int total = ne * ne * ve;
    bit mFail = 0;
    int mPass = 0;
    int mVec = 0;
    @(negedge clk);
    start = 1'b1; speedFactor = 4'(n); vecCount = 4'(v);
    @(negedge clk);
    start = 1'b0;
    // R10: accepted start cleared status
    chk(!done && !failSticky && failPass == 0 && failVec == 0, "R10 status cleared",
        {done, failSticky}, 0);
    for (int t = 0; t < total; t++) begin
      int ph = t % ne + 1;
      int k = t / (ne * ve) + 1;
      int vi = (t / ne) % ve;
      bit st = (ph == k);
      start = 1'b0;
      chk(busy == 1'b1 && done == 1'b0, "R2 busy during run", busy, 1);
      chk(applyPulse == (ph == 1), "R3 apply position", applyPulse, ph == 1);
      chk(vecIndex == 4'(vi), "R3 vector index", vecIndex, vi);
      chk(strobe == st, "R4 strobe position", strobe, st);
      chk(passNum == 4'(k), "R5 pass number", passNum, k);
      chk(captured == 8'(expCap), "R7 captured word", captured, expCap);
      chk(failSticky == mFail, "R8 fail flag", failSticky, mFail);
      expData = 8'($urandom);
      if (st) begin
        bit bad = (k == injP && vi == injV) || (inj2 && k == ne && vi == ve - 1);
        cutOut = bad ? (expData ^ 8'h01) : expData;
        expCap = cutOut;
        if (bad && !mFail) begin
          mFail = 1; mPass = k; mVec = vi;
        end
      end else begin
        cutOut = ~expData;
      end
      if (t == midT) begin
        start = 1'b1; speedFactor = 4'(ne == 15 ? 3 : 15); vecCount = 4'(ve + 1);
      end
      @(negedge clk);
    end
    start = 1'b0;
    chk(busy == 1'b0 && done == 1'b1, "R6 done after last pass", {busy, done}, 1);
    chk(applyPulse == 1'b0 && strobe == 1'b0, "R6 quiet when done", {applyPulse, strobe}, 0);
    chk(captured == 8'(expCap), "R7 final captured", captured, expCap);
    chk(failSticky == mFail, "R8 final fail flag", failSticky, mFail);
    chk(failPass == 4'(mPass), "R8 first fail pass", failPass, mPass);
    chk(failVec == 4'(mVec), "R8 first fail vector", failVec, mVec);
    if (midT >= 0) chk(done == 1'b1, "R9 stray start ignored", done, 1);
    repeat (2) @(negedge clk);
    chk(done == 1'b1 && busy == 1'b0, "R6 done holds", done, 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(!busy && !done && !applyPulse && !strobe && !failSticky, "R1 reset flags",
        {busy, done, applyPulse, strobe, failSticky}, 0);
    chk(passNum == 0 && vecIndex == 0 && failPass == 0 && failVec == 0 && captured == 0,
        "R1 reset values", captured, 0);
    runTest(2, 3, 1, 1, 1'b1, -1);   // R4 N=2 offsets 1 and 2, R8 two mismatches
    runTest(0, 3, 0, 0, 1'b0, -1);   // R2 N=0 taken as 1
    runTest(1, 0, 1, 0, 1'b0, -1);   // R2 V=0 taken as 1, R10 clears prior fail next run
    runTest(15, 2, 15, 1, 1'b0, 40); // R9 stray start, R4 k=N=15
    runTest(3, 4, 0, 0, 1'b0, 5);    // R10 fail cleared from previous run
    for (int r = 0; r < 6; r++) begin
      int n = 1 + ($urandom % 15);
      int v = 1 + ($urandom % 6);
      int ip = ($urandom % 2) ? 1 + ($urandom % n) : 0;
      int iv = $urandom % v;
      runTest(n, v, ip, iv, 1'(r % 2), (r == 2) ? 3 : -1);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        checks++;
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end
endmodule